// File: doc/BRIEF.md
# Address Bus Tenure Acquisition Controller

This controller sits on the master side of a shared address bus. It decides when its processor may take ownership of the bus for an address tenure, and it drives the shared bus-busy line. A transaction engine raises a one-cycle start strobe and may withdraw the work with a cancel strobe. The controller then asks the arbiter for the bus, watches the grant, the busy line driven by other masters and the address retry line, and reports ownership back to the engine.

Every bus input is registered once on the rising edge before any decision uses it. A grant counts as qualified when the sampled grant is high and the sampled busy and retry lines are both low. The master does not need to have raised its request first, so a grant that is parked on this master is taken as soon as work appears. Because the decision uses the registered grant, a grant that lasted only one cycle is still honoured in the cycle after it was removed.

During a tenure the controller drives bus-busy high with its output enabled. After the address acknowledge it drives the negated level for a release phase and then disables the output. A retry seen in the cycle after the acknowledge keeps the transaction pending, and arbitration starts again.

Top module: `abus_tenure_ctrl`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, the ownership output, the bus request, the busy drive value and the busy output-enable are all 0.
- R2: The bus request equals (transaction pending) AND (cancel strobe low) AND (controller neither owning nor releasing). It follows the cancel strobe in the same cycle and is 0 from the cycle ownership rises.
- R3: If grant=1, busy=0 and retry=0 are present on the pins in cycle c, and a transaction is pending and not cancelled in cycle c+1, ownership rises in cycle c+2.
- R4: A grant that arrives together with busy=1 or retry=1 on the pins does not lead to ownership. Ownership follows two cycles after the first pin cycle in which grant is high and both busy and retry are low.
- R5: A grant held high for exactly one pin cycle, meeting the other conditions, still gives ownership two cycles later, although grant is already low by then.
- R6: A grant that is already high before the transaction starts is accepted without any request cycle being required. Ownership rises two cycles after the start strobe.
- R7: A cancel strobe while the controller is not owning clears the pending transaction. A cancel in the cycle in which a registered qualified grant is present prevents ownership, and no later tenure follows for that transaction.
- R8: While owning, the grant, busy and retry pins are ignored. Ownership lasts until an acknowledge is seen on the pins.
- R9: While owning, the busy drive value and the output-enable are both 1. If the acknowledge is on the pins in cycle c, then in cycle c+2 ownership is 0, the drive value is 0 and the output-enable is 1. In cycle c+3 the output-enable is 0. The release phase lasts RELEASE_CYCLES cycles (default 1).
- R10: Retry=1 on the pins in the cycle after the acknowledge keeps the transaction pending, so the request returns when the release phase ends. Retry=0 in that cycle completes the transaction, and the request stays 0.
- R11: A start strobe while a transaction is already pending, including during its tenure, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start_i | input | 1 | One-cycle strobe: a new address transaction is pending |
| tx_cancel_i | input | 1 | One-cycle strobe: withdraw the pending transaction |
| bus_grant_i | input | 1 | Arbiter grant, active high |
| bus_busy_i | input | 1 | Bus-busy as driven by other masters, active high |
| addr_retry_i | input | 1 | Address retry, active high |
| addr_ack_i | input | 1 | Address acknowledge, active high |
| bus_req_o | output | 1 | Request to the arbiter |
| tenure_own_o | output | 1 | This master owns the address bus |
| busy_drv_o | output | 1 | Value driven onto the bus-busy line |
| busy_oe_o | output | 1 | Output-enable for bus-busy (0 = released) |

## Verification
Each pin input goes through one register, so a grant seen on the pins in cycle c moves ownership in cycle c+2. An acknowledge in cycle c drops ownership and the drive value in cycle c+2 and the output-enable in cycle c+3. The request follows the cancel strobe combinationally, in the same cycle. The bench drives inputs on the falling edge and compares every output against a behavioural model 2 ns after each rising edge. Its directed checks wait exactly the number of edges given above before they sample.

// File: rtl/abt_pkg.sv
package abt_pkg;

    typedef enum logic [1:0] {
        ST_ARB = 2'd0,
        ST_OWN = 2'd1,
        ST_REL = 2'd2
    } tenure_st_e;

    typedef struct packed {
        logic grant;
        logic busy;
        logic retry;
        logic ack;
    } bus_smp_t;

endpackage

// File: rtl/abt_sampler.sv
module abt_sampler
    import abt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_smp_t pins_i,
    output bus_smp_t smp_o
);

    bus_smp_t smp_d, smp_q;

    always_comb begin
        smp_d = pins_i;
    end

    always_ff @(posedge clk) begin
        if (rst) smp_q <= '0;
        else     smp_q <= smp_d;
    end

    assign smp_o = smp_q;

endmodule

// File: rtl/abt_request.sv
module abt_request (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic cancel_i,
    input  logic arb_i,
    input  logic tenure_done_i,
    output logic pend_live_o,
    output logic req_o
);

    typedef struct packed {
        logic pend;
    } req_st_t;

    req_st_t d, q;

    always_comb begin
        d = q;
        if (tenure_done_i)                 d.pend = 1'b0;
        else if (arb_i && cancel_i)        d.pend = 1'b0;
        else if (start_i && !q.pend)       d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign pend_live_o = q.pend && !cancel_i;
    assign req_o       = q.pend && !cancel_i && arb_i;

    // R7
    cancel_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (arb_i && cancel_i) |=> !q.pend);

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (q.pend && !tenure_done_i && !(arb_i && cancel_i)) |=> q.pend);

endmodule

// File: rtl/abt_tenure_fsm.sv
module abt_tenure_fsm
    import abt_pkg::*;
#(
    parameter int RELEASE_CYCLES = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_smp_t smp_i,
    input  logic     pend_live_i,
    output logic     arb_o,
    output logic     own_o,
    output logic     drv_o,
    output logic     oe_o,
    output logic     tenure_done_o
);

    localparam int CW = (RELEASE_CYCLES > 1) ? $clog2(RELEASE_CYCLES) : 1;
    localparam logic [CW-1:0] REL_LOAD = CW'(RELEASE_CYCLES - 1);

    typedef struct packed {
        tenure_st_e    st;
        logic [CW-1:0] rel_cnt;
        logic          retry_seen;
    } fsm_st_t;

    fsm_st_t d, q;
    logic    qual;
    logic    first_rel;
    logic    retry_now;

    always_comb begin
        d             = q;
        tenure_done_o = 1'b0;
        qual      = (q.st == ST_ARB) && smp_i.grant && !smp_i.busy
                    && !smp_i.retry && pend_live_i;
        first_rel = (q.st == ST_REL) && (q.rel_cnt == REL_LOAD);
        retry_now = first_rel ? smp_i.retry : q.retry_seen;
        unique case (q.st)
            ST_ARB: begin
                if (qual) d.st = ST_OWN;
            end
            ST_OWN: begin
                if (smp_i.ack) begin
                    d.st         = ST_REL;
                    d.rel_cnt    = REL_LOAD;
                    d.retry_seen = 1'b0;
                end
            end
            ST_REL: begin
                if (first_rel) d.retry_seen = smp_i.retry;
                if (q.rel_cnt == '0) begin
                    d.st          = ST_ARB;
                    tenure_done_o = !retry_now;
                end else begin
                    d.rel_cnt = q.rel_cnt - 1'b1;
                end
            end
            default: d.st = ST_ARB;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: ST_ARB, rel_cnt: '0, retry_seen: 1'b0};
        else     q <= d;
    end

    assign arb_o = (q.st == ST_ARB);
    assign own_o = (q.st == ST_OWN);
    assign drv_o = (q.st == ST_OWN);
    assign oe_o  = (q.st == ST_OWN) || (q.st == ST_REL);

    // R3
    qual_take_chk: assert property (@(posedge clk) disable iff (rst)
        qual |=> own_o);

    // R8
    own_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (own_o && !smp_i.ack) |=> own_o);

    // R9
    rel_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (own_o && smp_i.ack) |=> (oe_o && !drv_o && !own_o));

endmodule

// File: rtl/abus_tenure_ctrl.sv
module abus_tenure_ctrl
    import abt_pkg::*;
#(
    parameter int RELEASE_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_start_i,
    input  logic tx_cancel_i,
    input  logic bus_grant_i,
    input  logic bus_busy_i,
    input  logic addr_retry_i,
    input  logic addr_ack_i,
    output logic bus_req_o,
    output logic tenure_own_o,
    output logic busy_drv_o,
    output logic busy_oe_o
);

    bus_smp_t pins, smp;
    logic     arb, pend_live, tenure_done;

    assign pins = '{grant: bus_grant_i, busy: bus_busy_i,
                    retry: addr_retry_i, ack: addr_ack_i};

    abt_sampler u_smp (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins),
        .smp_o  (smp)
    );

    abt_request u_req (
        .clk           (clk),
        .rst           (rst),
        .start_i       (tx_start_i),
        .cancel_i      (tx_cancel_i),
        .arb_i         (arb),
        .tenure_done_i (tenure_done),
        .pend_live_o   (pend_live),
        .req_o         (bus_req_o)
    );

    abt_tenure_fsm #(.RELEASE_CYCLES(RELEASE_CYCLES)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .smp_i         (smp),
        .pend_live_i   (pend_live),
        .arb_o         (arb),
        .own_o         (tenure_own_o),
        .drv_o         (busy_drv_o),
        .oe_o          (busy_oe_o),
        .tenure_done_o (tenure_done)
    );

    // R2
    req_own_excl_chk: assert property (@(posedge clk) disable iff (rst)
        tenure_own_o |-> !bus_req_o);

    // R9
    own_drives_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tenure_own_o) |-> (busy_oe_o && busy_drv_o));

    // R7
    cancel_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (!tenure_own_o && !busy_oe_o && tx_cancel_i) |=> !tenure_own_o);

endmodule

// File: tb/tb_abus_tenure_ctrl.sv
module tb_abus_tenure_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, cancel = 1'b0, grant = 1'b0, busy = 1'b0, retry = 1'b0, ack = 1'b0;
    logic req, own, drv, oe;

    int checks = 0;
    int bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    abus_tenure_ctrl dut (
        .clk(clk), .rst(rst), .tx_start_i(start), .tx_cancel_i(cancel),
        .bus_grant_i(grant), .bus_busy_i(busy), .addr_retry_i(retry),
        .addr_ack_i(ack), .bus_req_o(req), .tenure_own_o(own),
        .busy_drv_o(drv), .busy_oe_o(oe)
    );

    // behavioural reference: 0 arbitrating, 1 owning, 2 releasing
    int m_st = 0;
    bit m_pend = 0;
    bit m_g = 0, m_b = 0, m_r = 0, m_a = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_pend = 0; m_g = 0; m_b = 0; m_r = 0; m_a = 0;
        end else begin
            if (m_st == 0) begin
                if (m_g && !m_b && !m_r && m_pend && !cancel) m_st = 1;
                else if (cancel) m_pend = 0;
                else if (start && !m_pend) m_pend = 1;
            end else if (m_st == 1) begin
                if (m_a) m_st = 2;
            end else begin
                if (!m_r) m_pend = 0;
                m_st = 0;
            end
            m_g = grant; m_b = busy; m_r = retry; m_a = ack;
        end
    end

    task automatic chk(input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (cmp_on && !done) begin
            chk(req, m_pend && !cancel && (m_st == 0), "R2 model bus_req");
            chk(own, m_st == 1, "R3 model own");
            chk(drv, m_st == 1, "R9 model drive");
            chk(oe,  m_st != 0, "R9 model oe");
        end
    end

    task automatic at_edge();
        @(posedge clk); #2;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        at_edge();
        chk(own, 1'b0, "R1 reset own"); chk(req, 1'b0, "R1 reset req");
        chk(oe, 1'b0, "R1 reset oe");   chk(drv, 1'b0, "R1 reset drv");
        @(negedge clk) rst = 1'b0;
        cmp_on = 1'b1;

        // R6 parked grant, R3 timing
        @(negedge clk) grant = 1'b1;
        @(negedge clk) start = 1'b1;
        at_edge();
        chk(req, 1'b1, "R2 request after start"); chk(own, 1'b0, "R6 own not yet");
        @(negedge clk) start = 1'b0;
        at_edge();
        chk(own, 1'b1, "R6 parked grant taken"); chk(req, 1'b0, "R2 req drops at own");
        // R8 pins ignored while owning, R11 start ignored
        @(negedge clk) begin grant = 1'b0; busy = 1'b1; retry = 1'b1; start = 1'b1; end
        @(negedge clk) begin grant = 1'b1; start = 1'b0; end
        @(negedge clk) begin grant = 1'b0; busy = 1'b0; retry = 1'b0; end
        at_edge();
        chk(own, 1'b1, "R8 ownership held");
        @(negedge clk) ack = 1'b1;
        at_edge();
        chk(own, 1'b1, "R9 own one cycle after ack");
        @(negedge clk) ack = 1'b0;
        at_edge();
        chk(own, 1'b0, "R9 own dropped"); chk(oe, 1'b1, "R9 oe in release");
        chk(drv, 1'b0, "R9 negated drive");
        at_edge();
        chk(oe, 1'b0, "R9 released");
        chk(req, 1'b0, "R10 R11 no request after clean tenure");

        // R4 busy and retry block
        @(negedge clk) start = 1'b1;
        @(negedge clk) begin start = 1'b0; grant = 1'b1; busy = 1'b1; end
        at_edge(); at_edge(); at_edge();
        chk(own, 1'b0, "R4 busy blocks");
        @(negedge clk) begin busy = 1'b0; retry = 1'b1; end
        at_edge(); at_edge(); at_edge();
        chk(own, 1'b0, "R4 retry blocks");
        @(negedge clk) retry = 1'b0;
        at_edge();
        chk(own, 1'b0, "R4 not yet");
        at_edge();
        chk(own, 1'b1, "R4 own after clear");
        // R10 retried tenure
        @(negedge clk) begin grant = 1'b0; ack = 1'b1; end
        at_edge();
        @(negedge clk) begin ack = 1'b0; retry = 1'b1; end
        at_edge();
        chk(oe, 1'b1, "R9 oe during release");
        @(negedge clk) retry = 1'b0;
        at_edge();
        chk(req, 1'b1, "R10 retry keeps pending");
        // R5 one-cycle grant
        @(negedge clk) grant = 1'b1;
        at_edge();
        @(negedge clk) grant = 1'b0;
        at_edge();
        chk(own, 1'b1, "R5 late honoured grant");
        @(negedge clk) ack = 1'b1;
        at_edge();
        @(negedge clk) ack = 1'b0;
        at_edge(); at_edge();
        chk(req, 1'b0, "R10 completed after retry");

        // R7 cancel in qualification cycle
        @(negedge clk) start = 1'b1;
        at_edge();
        @(negedge clk) begin start = 1'b0; grant = 1'b1; end
        at_edge();
        @(negedge clk) cancel = 1'b1;
        #1 chk(req, 1'b0, "R2 req follows cancel");
        at_edge();
        chk(own, 1'b0, "R7 cancel blocks own");
        @(negedge clk) cancel = 1'b0;
        at_edge(); at_edge();
        chk(own, 1'b0, "R7 no later tenure"); chk(req, 1'b0, "R7 pending cleared");
        @(negedge clk) grant = 1'b0;

        // mixed stimulus against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            start  = ($urandom % 6) == 0;
            cancel = ($urandom % 13) == 0;
            grant  = ($urandom % 3) != 0;
            busy   = ($urandom % 4) == 0;
            retry  = ($urandom % 5) == 0;
            ack    = ($urandom % 4) == 0;
        end
        @(negedge clk);
        finish_run();
    end

endmodule